// File: doc/BRIEF.md
# DMA Controller Register Bank and Interrupt Unit

This block is the software-visible face of a multi-channel DMA controller. It decodes a 4 KB window of 32-bit words into three areas. The low area holds the controller-wide registers. A channel area gives each channel a 32-byte slot. The top eight words hold read-only identification bytes. The block holds every channel's source address, destination address, link pointer, control word and configuration word, and presents all of them in parallel to the transfer engines. Data movement happens outside this block.

The transfer engines report events back through one-cycle set pulses, one bit per channel, for terminal count (TC) and for error. The block keeps these as raw sticky bits. Software clears them by writing ones. Each channel's configuration word masks its own bits, and the block drives a TC line, an error line and a combined line.

The register port uses plain strobes. An access is accepted in the cycle its strobe is high, with no wait state and no back-pressure. Read data appears one cycle after the read strobe.

Top module: `dma_regbank`

## Requirements
- R1: In the channel area (offset bits [11:8] = 1), offset bits [7:5] pick the channel and bits [4:2] pick the register: 0 source, 1 destination, 2 link pointer, 3 control, 4 configuration. A write stores the full word. It reads back at that offset, and it appears on the matching slice `[c*32 +: 32]` of the exported channel bus.
- R2: These accesses are bad offsets, which read zero and ignore writes:
  - a channel access whose index is at or above NUM_CH, or whose register select is 5 to 7;
  - a global word 14 or 15;
  - any offset from 0x200 to 0xFDF.
- R3: A set pulse on `tc_set[c]` or `err_set[c]` sets raw bit c, and the bit stays set until it is cleared. Raw TC reads at global word 5 and raw error reads at word 6. Channel c is bit c.
- R4: A write to global word 2 clears every raw TC bit where the written data has a one. A write to word 4 does the same for raw error bits. A set pulse in the same cycle as the clear wins for its bit.
- R5: The TC mask of channel c is configuration bit 15, and the error mask is configuration bit 14. Word 1 reads raw TC AND the TC mask. Word 3 reads raw error AND the error mask. Word 0 reads the OR of the two.
- R6: `irq_tc` is high when any masked TC bit is set, and `irq_err` is high when any masked error bit is set. `irq_any` is the OR of the two. All three follow the registered state with no extra delay.
- R7: Global word 7 reads bit 0 of each channel's configuration word, with channel c at bit c.
- R8: Word offsets 0xFE0 to 0xFFC read one identification byte each, in bits [7:0]. In order they are: 0x80 (0x81 when NUM_CH is 2), 0x10, 0x04, 0x0A, 0x0D, 0xF0, 0x05, 0xB1. Writes to these offsets are ignored.
- R9: Global word 12 (controller configuration) and word 13 (sync) store and read back the full word. Bit 0 of word 12 drives `ctl_enable`. Words 8 to 11 (software requests) and the clear words 2 and 4 read zero.
- R10: `bus_rdata` is updated at the clock edge that samples `bus_re`, using the register state from before that edge. It holds its value while `bus_re` is low.
- R11: After reset, every channel register, raw interrupt bit, configuration, sync and `bus_rdata` is zero, and all three interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte offset in the window; bits [1:0] ignored |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| tc_set | input | NUM_CH | Terminal-count set pulses from the engines |
| err_set | input | NUM_CH | Error set pulses from the engines |
| chan_src | output | NUM_CH*32 | Source address of each channel |
| chan_dst | output | NUM_CH*32 | Destination address of each channel |
| chan_link | output | NUM_CH*32 | Link pointer of each channel |
| chan_ctrl | output | NUM_CH*32 | Control word of each channel |
| chan_cfg | output | NUM_CH*32 | Configuration word of each channel |
| ctl_enable | output | 1 | Controller enable (configuration bit 0) |
| irq_tc | output | 1 | Masked terminal-count interrupt |
| irq_err | output | 1 | Masked error interrupt |
| irq_any | output | 1 | OR of the two interrupt lines |

## Verification
A read is due one clock edge after its strobe, and it carries the state from before that edge. The bench therefore computes the expected word from its model before it applies that cycle's write and set pulses, then samples on the following falling edge. Writes, clears and set pulses act at the same edge, so the interrupt lines, the exported channel words and `ctl_enable` are compared on that same falling edge, after the model has been updated. Holding of `bus_rdata` is checked over idle cycles that follow a read.

// File: rtl/dmarb_pkg.sv
package dmarb_pkg;
  localparam int REG_W = 32;

  typedef enum logic [2:0] {
    SEL_SRC  = 3'd0,
    SEL_DST  = 3'd1,
    SEL_LINK = 3'd2,
    SEL_CTRL = 3'd3,
    SEL_CFG  = 3'd4
  } chsel_e;

  localparam int CFG_EN_BIT      = 0;
  localparam int CFG_ERRMASK_BIT = 14;
  localparam int CFG_TCMASK_BIT  = 15;

  localparam logic [5:0] GW_STAT    = 6'd0;
  localparam logic [5:0] GW_TCSTAT  = 6'd1;
  localparam logic [5:0] GW_TCCLR   = 6'd2;
  localparam logic [5:0] GW_ERRSTAT = 6'd3;
  localparam logic [5:0] GW_ERRCLR  = 6'd4;
  localparam logic [5:0] GW_TCRAW   = 6'd5;
  localparam logic [5:0] GW_ERRRAW  = 6'd6;
  localparam logic [5:0] GW_ENMAP   = 6'd7;
  localparam logic [5:0] GW_CTL     = 6'd12;
  localparam logic [5:0] GW_SYNC    = 6'd13;

  function automatic logic [7:0] id_byte(input logic [2:0] idx, input int nch);
    case (idx)
      3'd0:    id_byte = (nch == 2) ? 8'h81 : 8'h80;
      3'd1:    id_byte = 8'h10;
      3'd2:    id_byte = 8'h04;
      3'd3:    id_byte = 8'h0A;
      3'd4:    id_byte = 8'h0D;
      3'd5:    id_byte = 8'hF0;
      3'd6:    id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/dmarb_decode.sv
module dmarb_decode #(
  parameter int NUM_CH = 8
) (
  input  logic [11:0] addr,
  output logic        ch_hit,
  output logic [2:0]  ch_idx,
  output logic [2:0]  ch_sel,
  output logic        glob_hit,
  output logic [5:0]  gword,
  output logic        id_hit,
  output logic [2:0]  id_idx
);
  localparam logic [3:0] NCH4 = 4'(NUM_CH);

  logic unused_lsb;
  assign unused_lsb = ^addr[1:0];

  assign ch_idx   = addr[7:5];
  assign ch_sel   = addr[4:2];
  assign ch_hit   = (addr[11:8] == 4'h1) && ({1'b0, ch_idx} < NCH4) && (ch_sel <= 3'd4);
  assign gword    = addr[7:2];
  assign glob_hit = (addr[11:8] == 4'h0);
  assign id_hit   = (addr[11:5] == 7'h7F);
  assign id_idx   = addr[4:2];
endmodule

// File: rtl/dmarb_chan.sv
module dmarb_chan
  import dmarb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       sel,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] src,
  output logic [REG_W-1:0] dst,
  output logic [REG_W-1:0] link,
  output logic [REG_W-1:0] ctrl,
  output logic [REG_W-1:0] cfg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src  <= '0;
      dst  <= '0;
      link <= '0;
      ctrl <= '0;
      cfg  <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_SRC:  src  <= wdata;
        SEL_DST:  dst  <= wdata;
        SEL_LINK: link <= wdata;
        SEL_CTRL: ctrl <= wdata;
        SEL_CFG:  cfg  <= wdata;
        default:  ;
      endcase
    end
  end

  // R2: without a qualified write the slot keeps every word
  a_r2_slot_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable({src, dst, link, ctrl, cfg}));

  // R1: a qualified write lands in the selected word
  a_r1_src_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_SRC) |=> (src == $past(wdata)));
endmodule

// File: rtl/dmarb_irq.sv
module dmarb_irq #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] tc_set,
  input  logic [NUM_CH-1:0] err_set,
  input  logic              tc_clr_we,
  input  logic              err_clr_we,
  input  logic [NUM_CH-1:0] clr_val,
  input  logic [NUM_CH-1:0] tc_mask,
  input  logic [NUM_CH-1:0] err_mask,
  output logic [NUM_CH-1:0] raw_tc,
  output logic [NUM_CH-1:0] raw_err,
  output logic              irq_tc,
  output logic              irq_err,
  output logic              irq_any
);
  logic [NUM_CH-1:0] tc_clr, err_clr;

  assign tc_clr  = tc_clr_we  ? clr_val : '0;
  assign err_clr = err_clr_we ? clr_val : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_tc  <= '0;
      raw_err <= '0;
    end else begin
      raw_tc  <= (raw_tc  & ~tc_clr)  | tc_set;
      raw_err <= (raw_err & ~err_clr) | err_set;
    end
  end

  assign irq_tc  = |(raw_tc & tc_mask);
  assign irq_err = |(raw_err & err_mask);
  assign irq_any = irq_tc | irq_err;

  // R3: a set pulse is captured
  a_r3_tc_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (|tc_set) |=> ((raw_tc & $past(tc_set)) == $past(tc_set)));
  a_r3_err_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_set) |=> ((raw_err & $past(err_set)) == $past(err_set)));
  // R3: raw bits are sticky without a clear
  a_r3_tc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!tc_clr_we && !(|tc_set)) |=> $stable(raw_tc));
  // R4: a clear without competing sets empties the written bits
  a_r4_tc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_clr_we && !(|tc_set)) |=> ((raw_tc & $past(clr_val)) == '0));
  a_r4_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr_we && !(|err_set)) |=> ((raw_err & $past(clr_val)) == '0));
endmodule

// File: rtl/dma_regbank.sv
module dma_regbank
  import dmarb_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [11:0]             bus_addr,
  input  logic [31:0]             bus_wdata,
  input  logic                    bus_we,
  input  logic                    bus_re,
  output logic [31:0]             bus_rdata,
  input  logic [NUM_CH-1:0]       tc_set,
  input  logic [NUM_CH-1:0]       err_set,
  output logic [NUM_CH*REG_W-1:0] chan_src,
  output logic [NUM_CH*REG_W-1:0] chan_dst,
  output logic [NUM_CH*REG_W-1:0] chan_link,
  output logic [NUM_CH*REG_W-1:0] chan_ctrl,
  output logic [NUM_CH*REG_W-1:0] chan_cfg,
  output logic                    ctl_enable,
  output logic                    irq_tc,
  output logic                    irq_err,
  output logic                    irq_any
);
  localparam int PAD_W = REG_W - NUM_CH;

  logic        ch_hit, glob_hit, id_hit;
  logic [2:0]  ch_idx, ch_sel, id_idx;
  logic [5:0]  gword;

  logic [REG_W-1:0] src_q  [NUM_CH];
  logic [REG_W-1:0] dst_q  [NUM_CH];
  logic [REG_W-1:0] link_q [NUM_CH];
  logic [REG_W-1:0] ctrl_q [NUM_CH];
  logic [REG_W-1:0] cfg_q  [NUM_CH];

  logic [NUM_CH-1:0] tc_mask, err_mask, en_map, raw_tc, raw_err;
  logic [REG_W-1:0]  gcfg_q, sync_q, rd_next;

  dmarb_decode #(.NUM_CH(NUM_CH)) u_dec (
    .addr     (bus_addr),
    .ch_hit   (ch_hit),
    .ch_idx   (ch_idx),
    .ch_sel   (ch_sel),
    .glob_hit (glob_hit),
    .gword    (gword),
    .id_hit   (id_hit),
    .id_idx   (id_idx)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic we_c;
    assign we_c = bus_we && ch_hit && (ch_idx == 3'(c));

    dmarb_chan u_chan (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (we_c),
      .sel   (ch_sel),
      .wdata (bus_wdata),
      .src   (src_q[c]),
      .dst   (dst_q[c]),
      .link  (link_q[c]),
      .ctrl  (ctrl_q[c]),
      .cfg   (cfg_q[c])
    );

    assign chan_src [c*REG_W +: REG_W] = src_q[c];
    assign chan_dst [c*REG_W +: REG_W] = dst_q[c];
    assign chan_link[c*REG_W +: REG_W] = link_q[c];
    assign chan_ctrl[c*REG_W +: REG_W] = ctrl_q[c];
    assign chan_cfg [c*REG_W +: REG_W] = cfg_q[c];
    assign tc_mask[c]  = cfg_q[c][CFG_TCMASK_BIT];
    assign err_mask[c] = cfg_q[c][CFG_ERRMASK_BIT];
    assign en_map[c]   = cfg_q[c][CFG_EN_BIT];
  end

  dmarb_irq #(.NUM_CH(NUM_CH)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .tc_set     (tc_set),
    .err_set    (err_set),
    .tc_clr_we  (bus_we && glob_hit && gword == GW_TCCLR),
    .err_clr_we (bus_we && glob_hit && gword == GW_ERRCLR),
    .clr_val    (bus_wdata[NUM_CH-1:0]),
    .tc_mask    (tc_mask),
    .err_mask   (err_mask),
    .raw_tc     (raw_tc),
    .raw_err    (raw_err),
    .irq_tc     (irq_tc),
    .irq_err    (irq_err),
    .irq_any    (irq_any)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gcfg_q <= '0;
      sync_q <= '0;
    end else if (bus_we && glob_hit) begin
      if (gword == GW_CTL)  gcfg_q <= bus_wdata;
      if (gword == GW_SYNC) sync_q <= bus_wdata;
    end
  end

  assign ctl_enable = gcfg_q[0];

  always_comb begin
    rd_next = '0;
    if (ch_hit) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (ch_idx == 3'(c)) begin
          case (ch_sel)
            SEL_SRC:  rd_next = src_q[c];
            SEL_DST:  rd_next = dst_q[c];
            SEL_LINK: rd_next = link_q[c];
            SEL_CTRL: rd_next = ctrl_q[c];
            SEL_CFG:  rd_next = cfg_q[c];
            default:  rd_next = '0;
          endcase
        end
      end
    end else if (glob_hit) begin
      case (gword)
        GW_STAT:    rd_next = {{PAD_W{1'b0}}, (raw_tc & tc_mask) | (raw_err & err_mask)};
        GW_TCSTAT:  rd_next = {{PAD_W{1'b0}}, raw_tc & tc_mask};
        GW_ERRSTAT: rd_next = {{PAD_W{1'b0}}, raw_err & err_mask};
        GW_TCRAW:   rd_next = {{PAD_W{1'b0}}, raw_tc};
        GW_ERRRAW:  rd_next = {{PAD_W{1'b0}}, raw_err};
        GW_ENMAP:   rd_next = {{PAD_W{1'b0}}, en_map};
        GW_CTL:     rd_next = gcfg_q;
        GW_SYNC:    rd_next = sync_q;
        default:    rd_next = '0;
      endcase
    end else if (id_hit) begin
      rd_next = {24'd0, id_byte(id_idx, NUM_CH)};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_next;
  end

  // R10: read data holds between reads
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> $stable(bus_rdata));
  // R5: the TC line needs at least one channel with its TC mask set
  a_r5_tc_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tc |-> (|tc_mask));
  // R9: the enable output follows a write to the configuration word
  a_r9_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && glob_hit && gword == GW_CTL) |=> (ctl_enable == $past(bus_wdata[0])));
endmodule

// File: tb/dma_regbank_tb.sv
`timescale 1ns/1ps
module dma_regbank_tb;
  localparam int NCH = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] tc_set = '0, err_set = '0;
  logic [NCH*32-1:0] chan_src, chan_dst, chan_link, chan_ctrl, chan_cfg;
  logic ctl_enable, irq_tc, irq_err, irq_any;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] m_reg [NCH][5];
  logic [31:0] m_gcfg, m_sync;
  logic [NCH-1:0] m_tc, m_err;

  always #2.5 clk = ~clk;

  dma_regbank #(.NUM_CH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .tc_set(tc_set), .err_set(err_set),
    .chan_src(chan_src), .chan_dst(chan_dst), .chan_link(chan_link),
    .chan_ctrl(chan_ctrl), .chan_cfg(chan_cfg), .ctl_enable(ctl_enable),
    .irq_tc(irq_tc), .irq_err(irq_err), .irq_any(irq_any)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [NCH-1:0] tmask();
    for (int c = 0; c < NCH; c++) tmask[c] = m_reg[c][4][15];
  endfunction
  function automatic logic [NCH-1:0] emask();
    for (int c = 0; c < NCH; c++) emask[c] = m_reg[c][4][14];
  endfunction

  function automatic logic [7:0] exp_id(input int i);
    case (i)
      0: exp_id = 8'h80; 1: exp_id = 8'h10; 2: exp_id = 8'h04; 3: exp_id = 8'h0A;
      4: exp_id = 8'h0D; 5: exp_id = 8'hF0; 6: exp_id = 8'h05; default: exp_id = 8'hB1;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    int idx, sel;
    logic [NCH-1:0] en;
    idx = int'(a[7:5]);
    sel = int'(a[4:2]);
    exp_rd = '0;
    if (a[11:8] == 4'h1) begin
      if (sel <= 4 && idx < NCH) exp_rd = m_reg[idx][sel];
    end else if (a[11:8] == 4'h0) begin
      for (int c = 0; c < NCH; c++) en[c] = m_reg[c][4][0];
      case (int'(a[7:2]))
        0:  exp_rd = 32'((m_tc & tmask()) | (m_err & emask()));
        1:  exp_rd = 32'(m_tc & tmask());
        3:  exp_rd = 32'(m_err & emask());
        5:  exp_rd = 32'(m_tc);
        6:  exp_rd = 32'(m_err);
        7:  exp_rd = 32'(en);
        12: exp_rd = m_gcfg;
        13: exp_rd = m_sync;
        default: exp_rd = '0;
      endcase
    end else if (a[11:5] == 7'h7F) begin
      exp_rd = {24'd0, exp_id(int'(a[4:2]))};
    end
  endfunction

  task automatic model_upd(input bit we, input logic [11:0] a, input logic [31:0] wd,
                           input logic [NCH-1:0] ts, input logic [NCH-1:0] es);
    if (we) begin
      if (a[11:8] == 4'h1 && a[4:2] <= 3'd4) m_reg[int'(a[7:5])][int'(a[4:2])] = wd;
      else if (a[11:8] == 4'h0) begin
        case (int'(a[7:2]))
          2:  m_tc  = m_tc  & ~wd[NCH-1:0];
          4:  m_err = m_err & ~wd[NCH-1:0];
          12: m_gcfg = wd;
          13: m_sync = wd;
          default: ;
        endcase
      end
    end
    m_tc  = m_tc  | ts;
    m_err = m_err | es;
  endtask

  // one bus cycle: read expectation from pre-edge state, lines checked after the edge
  task automatic op(input bit we, input bit re, input logic [11:0] a, input logic [31:0] wd,
                    input logic [NCH-1:0] ts, input logic [NCH-1:0] es, input string tag);
    logic [31:0] e;
    bit et, ee;
    e = exp_rd(a);
    @(negedge clk);
    bus_we = we; bus_re = re; bus_addr = a; bus_wdata = wd; tc_set = ts; err_set = es;
    @(negedge clk);
    bus_we = 0; bus_re = 0; tc_set = '0; err_set = '0;
    model_upd(we, a, wd, ts, es);
    if (re) chk(tag, bus_rdata, e);
    et = |(m_tc & tmask());
    ee = |(m_err & emask());
    chk("R6 irq lines", {29'd0, irq_any, irq_err, irq_tc}, {29'd0, et | ee, ee, et});
    chk("R9 ctl_enable", {31'd0, ctl_enable}, {31'd0, m_gcfg[0]});
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    op(1, 0, a, d, '0, '0, "write");
  endtask
  task automatic rd(input logic [11:0] a, input string tag);
    op(0, 1, a, '0, '0, '0, tag);
  endtask

  function automatic logic [11:0] rnd_addr();
    case ($urandom % 5)
      0, 1: rnd_addr = 12'h100 | 12'(($urandom % 8) << 5) | 12'(($urandom % 8) << 2);
      2:    rnd_addr = 12'(($urandom % 16) << 2);
      3:    rnd_addr = 12'hFE0 | 12'(($urandom % 8) << 2);
      default: rnd_addr = 12'($urandom) & 12'hFFC;
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd1234));
    for (int c = 0; c < NCH; c++) for (int s = 0; s < 5; s++) m_reg[c][s] = '0;
    m_gcfg = '0; m_sync = '0; m_tc = '0; m_err = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R11: reset state
    chk("R11 rdata after reset", bus_rdata, '0);
    for (int w = 0; w < 14; w++) rd(12'(w << 2), "R11 global word after reset");
    for (int s = 0; s < 5; s++) rd(12'h100 | 12'(s << 2), "R11 channel word after reset");

    // R1: channel slots and export bus
    for (int c = 0; c < NCH; c++)
      for (int s = 0; s < 5; s++) wr(12'h100 | 12'(c << 5) | 12'(s << 2), {8'(c), 8'(s), 16'hA5C3} ^ 32'(c * 77));
    for (int c = 0; c < NCH; c++) begin
      for (int s = 0; s < 5; s++) rd(12'h100 | 12'(c << 5) | 12'(s << 2), "R1 channel readback");
      chk("R1 export src",  chan_src [c*32 +: 32], m_reg[c][0]);
      chk("R1 export dst",  chan_dst [c*32 +: 32], m_reg[c][1]);
      chk("R1 export link", chan_link[c*32 +: 32], m_reg[c][2]);
      chk("R1 export ctrl", chan_ctrl[c*32 +: 32], m_reg[c][3]);
      chk("R1 export cfg",  chan_cfg [c*32 +: 32], m_reg[c][4]);
    end

    // R2: bad offsets
    wr(12'h114, 32'hDEADBEEF);
    rd(12'h114, "R2 select 5 reads zero");
    rd(12'h110, "R2 select 5 write left cfg untouched");
    wr(12'h03C, 32'h12345678);
    rd(12'h03C, "R2 global word 15 reads zero");
    wr(12'h300, 32'hFFFFFFFF);
    rd(12'h300, "R2 gap reads zero");

    // R8: identification bytes
    for (int i = 0; i < 8; i++) rd(12'hFE0 | 12'(i << 2), "R8 id byte");
    wr(12'hFE0, 32'h0);
    rd(12'hFE0, "R8 id ignores write");

    // R9: configuration, sync, software request words
    wr(12'h030, 32'h00000007);
    rd(12'h030, "R9 configuration readback");
    wr(12'h034, 32'hCAFEF00D);
    rd(12'h034, "R9 sync readback");
    wr(12'h020, 32'hFFFFFFFF);
    rd(12'h020, "R9 software request reads zero");
    rd(12'h008, "R9 clear word reads zero");

    // R3 R5 R6: masked interrupts
    wr(12'h170, 32'h0000_8001);
    wr(12'h190, 32'h0000_4000);
    op(0, 0, 12'h0, '0, 8'h08, 8'h10, "R3 set pulses");
    rd(12'h014, "R3 raw TC");
    rd(12'h018, "R3 raw error");
    rd(12'h004, "R5 masked TC");
    rd(12'h00C, "R5 masked error");
    rd(12'h000, "R5 combined status");
    rd(12'h01C, "R7 enabled map");

    // R4: clear and set priority
    op(1, 0, 12'h008, 32'h0000_0008, 8'h08, 8'h00, "R4 set beats clear");
    rd(12'h014, "R4 set wins over clear");
    wr(12'h008, 32'hFFFF_FFFF);
    rd(12'h014, "R4 TC clear");
    wr(12'h010, 32'h0000_0010);
    rd(12'h018, "R4 error clear");

    // R10: hold between reads
    rd(12'h034, "R10 read");
    held = bus_rdata;
    repeat (4) @(negedge clk);
    chk("R10 rdata holds", bus_rdata, held);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [11:0] a;
      logic [NCH-1:0] ts, es;
      a  = rnd_addr();
      ts = ($urandom % 4 == 0) ? NCH'($urandom) : '0;
      es = ($urandom % 4 == 0) ? NCH'($urandom) : '0;
      op(($urandom % 2) == 1, ($urandom % 2) == 1, a, $urandom, ts, es,
         "R1 R2 R3 R4 R5 R7 R8 R9 random read");
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule